// File: doc/BRIEF.md
# Stream Packet Size Tagger

This block sits on the transmit side, between a user packet stream and a 64-bit framed link stream. Each 64-bit beat carries two 32-bit words. The earlier word is in bits 31:0 and the later word is in bits 63:32. A packet of n words takes ceil(n/2) beats. When n is odd, the upper half of the final beat carries no meaning.

The block works out each packet's word count in one of two ways. In dynamic mode it reads the count from the sideband field on the packet's first beat. In static mode it uses a fixed parameter value. It then puts one header beat carrying that count on the link side, ahead of the payload. After the header, payload beats pass straight through in the same cycle, with backpressure carried from the link side back to the user side. No packet is buffered.

A tracker compares the beat that carries the last-beat flag with the count that was declared. It also checks the declared count against the legal range. Either kind of mismatch raises a sticky error flag.

Top module: `pkt_size_tagger`

## Requirements
- R1: When the first beat of a packet is offered, the output presents a header beat before any payload. The header has the word count in bits 6:0, zero in bits 63:7 and out_last_o low. in_ready_o stays low until the header is accepted.
- R2: In dynamic mode (DYNAMIC=1) the word count is in_user_i[6:0], sampled on the packet's first beat. in_user_i[7] has no effect.
- R3: in_user_i has no effect on any beat after the first one in a packet.
- R4: In static mode (DYNAMIC=0) every header carries STATIC_WORDS, and in_user_i has no effect.
- R5: After the header, each input beat appears on the output in the same cycle, with data and last flag unchanged. The earlier word stays in bits 31:0. For an odd count, the meaningless upper half of the final beat is forwarded as given.
- R6: While the header is being driven, in_ready_o is low. During payload, in_ready_o equals out_ready_i.
- R7: A packet of n words (1 to 126) whose last flag sits on beat ceil(n/2)-1 and on no earlier beat leaves err_o low. This includes odd n and the limit n=126.
- R8: err_o goes high when the last flag arrives on a beat before ceil(n/2)-1, or is missing on beat ceil(n/2)-1.
- R9: err_o goes high when the declared word count is 0 or greater than 126.
- R10: After reset, out_valid_o and err_o are low. Once high, err_o stays high until reset.
- R11: After the payload beat carrying the last flag is accepted, the block returns to driving a header for the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | User beat valid |
| in_ready_o | output | 1 | User beat accepted when high with valid |
| in_data_i | input | 64 | User beat, two 32-bit words |
| in_last_i | input | 1 | Final beat of the packet |
| in_user_i | input | 8 | Sideband field; bits 6:0 give the word count on the first beat |
| out_valid_o | output | 1 | Link beat valid |
| out_ready_i | input | 1 | Link side accepts the beat |
| out_data_o | output | 64 | Header or payload beat |
| out_last_o | output | 1 | Final payload beat |
| err_o | output | 1 | Sticky size or length mismatch flag |

## Verification
On every cycle, assertions check the following:
- Each declared count outside 1 to 126 raises the error flag in the next cycle.
- A last flag on the wrong beat raises the error flag in the next cycle.
- The error flag never falls without a reset.
- Once a header is accepted, the payload ready follows the link ready.
- After a packet ends, the block drives a new header.

Only the bench's scenarios can show the following:
- The exact header contents in both modes.
- That sideband bit 7 and later sideband values are ignored.
- Data and word-order transparency.
- Stall handling.
- The boundary counts 0, 126 and 127.

// File: rtl/pkt_size_pkg.sv
package pkt_size_pkg;
  typedef enum logic {
    ST_HDR  = 1'b0,
    ST_BODY = 1'b1
  } tag_state_e;
endpackage

// File: rtl/pkt_size_src.sv
module pkt_size_src #(
  parameter int unsigned USER_W       = 8,
  parameter int unsigned SIZE_W       = 7,
  parameter bit          DYNAMIC      = 1'b1,
  parameter int unsigned STATIC_WORDS = 8
) (
  input  logic [USER_W-1:0] user_i,
  output logic [SIZE_W-1:0] size_o
);
  logic unused_user;

  if (DYNAMIC) begin : g_dyn
    assign size_o      = user_i[SIZE_W-1:0];
    assign unused_user = ^user_i[USER_W-1:SIZE_W];
  end else begin : g_static
    assign size_o      = SIZE_W'(STATIC_WORDS);
    assign unused_user = ^user_i;
  end
endmodule

// File: rtl/pkt_beat_tracker.sv
module pkt_beat_tracker #(
  parameter int unsigned SIZE_W    = 7,
  parameter int unsigned MAX_WORDS = 126
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              beat_i,
  input  logic              last_i,
  output logic              err_o
);
  logic [SIZE_W-1:0] exp_q, cnt_q;
  logic [SIZE_W:0]   words_p1, cnt_p1;
  logic              size_bad, at_end, err_q;

  // ceil(n/2) beats
  assign words_p1 = {1'b0, size_i} + 1'b1;
  assign cnt_p1   = {1'b0, cnt_q} + 1'b1;
  assign size_bad = (size_i == '0) || (32'(size_i) > MAX_WORDS);
  assign at_end   = (cnt_p1 == {1'b0, exp_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (start_i) begin
        exp_q <= words_p1[SIZE_W:1];
        cnt_q <= '0;
        if (size_bad) err_q <= 1'b1;
      end else if (beat_i) begin
        if (!(&cnt_q)) cnt_q <= cnt_q + 1'b1;
        if (last_i != at_end) err_q <= 1'b1;
      end
    end
  end

  assign err_o = err_q;

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r9_bad_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && size_bad) |=> err_o);
  a_r8_len_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && !start_i && (last_i != at_end)) |=> err_o);
endmodule

// File: rtl/pkt_size_tagger.sv
module pkt_size_tagger
  import pkt_size_pkg::*;
#(
  parameter int unsigned DATA_W       = 64,
  parameter int unsigned USER_W       = 8,
  parameter int unsigned SIZE_W       = 7,
  parameter int unsigned MAX_WORDS    = 126,
  parameter bit          DYNAMIC      = 1'b1,
  parameter int unsigned STATIC_WORDS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  input  logic [USER_W-1:0] in_user_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o,
  output logic              err_o
);
  localparam int unsigned PAD_W = DATA_W - SIZE_W;

  tag_state_e        state_q;
  logic              in_hdr, hdr_fire, body_fire;
  logic [SIZE_W-1:0] size_w;

  pkt_size_src #(
    .USER_W(USER_W), .SIZE_W(SIZE_W),
    .DYNAMIC(DYNAMIC), .STATIC_WORDS(STATIC_WORDS)
  ) u_src (
    .user_i(in_user_i),
    .size_o(size_w)
  );

  assign in_hdr    = (state_q == ST_HDR);
  assign hdr_fire  = in_hdr && in_valid_i && out_ready_i;
  assign body_fire = !in_hdr && in_valid_i && out_ready_i;

  assign out_valid_o = in_valid_i;
  assign out_data_o  = in_hdr ? {{PAD_W{1'b0}}, size_w} : in_data_i;
  assign out_last_o  = !in_hdr && in_last_i;
  assign in_ready_o  = !in_hdr && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      state_q <= ST_HDR;
    else if (hdr_fire)                state_q <= ST_BODY;
    else if (body_fire && in_last_i)  state_q <= ST_HDR;
  end

  pkt_beat_tracker #(
    .SIZE_W(SIZE_W), .MAX_WORDS(MAX_WORDS)
  ) u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(hdr_fire),
    .size_i (size_w),
    .beat_i (body_fire),
    .last_i (in_last_i),
    .err_o  (err_o)
  );

  a_r11_new_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (body_fire && in_last_i) |=> !in_ready_o);
  a_r6_body_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_fire ##1 out_ready_i) |-> in_ready_o);
  a_r1_hdr_no_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !in_ready_o && out_ready_i) |-> !out_last_o);
endmodule

// File: tb/sim_pkt_size_tagger.sv
module sim_pkt_size_tagger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [63:0] in_data = '0;
  logic [7:0]  in_user = '0;
  logic        in_ready, out_valid, out_last, err;
  logic [63:0] out_data;
  logic        s_in_ready, s_out_valid, s_out_last, s_err;
  logic [63:0] s_out_data;
  int          checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  pkt_size_tagger u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_last_i(in_last), .in_user_i(in_user),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_last_o(out_last), .err_o(err));

  pkt_size_tagger #(.DYNAMIC(1'b0), .STATIC_WORDS(5)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(s_in_ready),
    .in_data_i(in_data), .in_last_i(in_last), .in_user_i(in_user),
    .out_valid_o(s_out_valid), .out_ready_i(1'b1), .out_data_o(s_out_data),
    .out_last_o(s_out_last), .err_o(s_err));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid && !err, "R10 reset state", {62'b0, out_valid, err}, 64'h0);
  endtask

  task automatic send_pkt(input string tag, input logic [7:0] user, input int nbeats,
                          input int last_idx, input bit stall, input bit exp_err,
                          input bit chk_static);
    logic [63:0] hdr;
    hdr = {57'b0, user[6:0]};
    @(negedge clk);
    in_valid = 1'b1; in_user = user; in_last = (last_idx == 0);
    in_data = 64'hA5A5_0000_0000_0001;
    #1;
    chk(out_valid && !out_last && out_data == hdr, {tag, " R1/R2 header"}, out_data, hdr);
    chk(!in_ready, {tag, " R6 ready low on header"}, {63'b0, in_ready}, 64'h0);
    if (chk_static)
      chk(s_out_data == 64'd5, {tag, " R4 static header"}, s_out_data, 64'd5);
    if (stall) begin
      out_ready = 1'b0;
      @(negedge clk);
      #1;
      chk(out_valid && out_data == hdr && !in_ready, {tag, " R6 header held"}, out_data, hdr);
      out_ready = 1'b1;
    end
    @(negedge clk);
    in_user = 8'hFF; // R3: later sideband values must not matter
    for (int i = 0; i < nbeats; i++) begin
      in_data = {32'hB000_0001 + 32'(2*i), 32'hB000_0000 + 32'(2*i)};
      if (i == last_idx && user[0]) in_data[63:32] = 32'hDEAD_BEEF;
      in_last = (i == last_idx);
      #1;
      chk(out_valid && out_data == in_data && out_last == in_last,
          {tag, " R5 pass-through"}, out_data, in_data);
      chk(in_ready == out_ready, {tag, " R6 ready follows link"}, {63'b0, in_ready}, {63'b0, out_ready});
      if (stall && i == 0) begin
        out_ready = 1'b0;
        #1;
        chk(!in_ready, {tag, " R6 body stall"}, {63'b0, in_ready}, 64'h0);
        @(negedge clk);
        out_ready = 1'b1;
      end
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    #1;
    chk(err == exp_err, {tag, " R7/R8/R9 error flag"}, {63'b0, err}, {63'b0, exp_err});
    chk(!in_ready && !out_valid, {tag, " R11 idle in header state"}, {63'b0, in_ready}, 64'h0);
    if (chk_static)
      chk(!s_err, {tag, " R4 static length ok"}, {63'b0, s_err}, 64'h0);
  endtask

  task automatic t_basic();
    do_reset();
    send_pkt("even8", 8'h08, 4, 3, 1'b0, 1'b0, 1'b0);
    send_pkt("odd5_bit7", 8'h85, 3, 2, 1'b0, 1'b0, 1'b0);
    send_pkt("one", 8'h01, 1, 0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_stall();
    do_reset();
    send_pkt("stall4", 8'h04, 2, 1, 1'b1, 1'b0, 1'b0);
    send_pkt("r11_next", 8'h03, 2, 1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_len_err();
    do_reset();
    send_pkt("r8_early", 8'h06, 2, 1, 1'b0, 1'b1, 1'b0);
    send_pkt("r10_sticky", 8'h02, 1, 0, 1'b0, 1'b1, 1'b0);
    do_reset();
    send_pkt("r8_missing", 8'h02, 3, 2, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_size_limits();
    do_reset();
    send_pkt("r7_max126", 8'h7E, 63, 62, 1'b0, 1'b0, 1'b0);
    do_reset();
    send_pkt("r9_zero", 8'h00, 1, 0, 1'b0, 1'b1, 1'b0);
    do_reset();
    send_pkt("r9_127", 8'h7F, 64, 63, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_static();
    do_reset();
    send_pkt("r4_static", 8'h02, 3, 2, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    t_basic();
    t_stall();
    t_len_err();
    t_size_limits();
    t_static();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule